// File: doc/BRIEF.md
# Text Cell Pixel Fetcher

This block turns a raster position into a colour index for a character-cell text screen. Every clock it takes the horizontal pixel counter and the line counter from an external timing generator, works out which cell and which row of that cell's bitmap the beam is on, and reads three synchronous memories: a code buffer holding one character code per cell, an attribute buffer laid out exactly like it with a colour pair per cell, and a glyph store of 8x8 bitmaps. The glyph bit under the beam picks either the cell's foreground or its background colour, and a 4-bit index leaves the block one pixel per clock.

Two screen geometries are selectable: 25 rows of 40 cells giving 320x200 pixels, or 25 rows of 80 cells where each bitmap row is repeated on two consecutive lines to fill 640x400. A cursor overlay, placed by a column and a row input and gated by a blink-phase bit, inverts the colours of the cell it covers. The memories sit outside the block. Each has one cycle of read latency, so the block runs as a fixed five-stage pipeline and the caller delays its sync signals by the same amount.

Top module: `txt_cell_render`

## Requirements
- R1: With wide_mode=0 the active area is x<320 and y<200. On the rising edge that samples the counters, cell_addr is loaded with (y/8)*40 + x/8.
- R2: With wide_mode=1 the active area is x<640 and y<400. The cell row is y/16, the bitmap row is (y/2) mod 8 and cell_addr is row*80 + x/8, so lines 2k and 2k+1 show the same pixels.
- R3: Two rising edges after the counters are sampled, gly_addr holds code*8 + bitmap row. code is the chr_data value returned for that cell, and the memory returns it one edge after cell_addr.
- R4: Bit 7-(x mod 8) of gly_data gives the pixel, so the MSB is the leftmost pixel. A 1 gives att_data[3:0] (foreground) and a 0 gives att_data[7:4] (background).
- R5: pix_color is loaded on the fourth rising edge after the edge that sampled the counters. A new counter value may arrive on every clock.
- R6: A counter position outside the active area of the current mode yields pix_color = 0.
- R7: When cur_blink=1 and the cell under the beam has column cur_col and row cur_row, that cell's foreground and background are exchanged. With cur_blink=0, or in any other cell, the overlay has no effect.
- R8: A synchronous active-high rst clears pix_color, cell_addr and gly_addr on the next rising edge. This includes a reset in mid-run with pixels in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 0: 40x25 cells, 1: 80x25 cells with line doubling |
| pix_x | input | 10 | Horizontal pixel counter |
| pix_y | input | 10 | Line counter |
| cur_col | input | 7 | Cursor cell column |
| cur_row | input | 5 | Cursor cell row |
| cur_blink | input | 1 | Blink phase; 1 shows the cursor overlay |
| cell_addr | output | 11 | Read address for the code and attribute buffers |
| chr_data | input | 8 | Character code from the code buffer (1-cycle latency) |
| att_data | input | 8 | Colour pair from the attribute buffer: background [7:4], foreground [3:0] |
| gly_addr | output | 11 | Read address for the glyph store |
| gly_data | input | 8 | Bitmap row from the glyph store (1-cycle latency) |
| pix_color | output | 4 | Colour index of the pixel |

## Verification
A counter value driven before rising edge k is due on cell_addr after edge k. It is due on gly_addr after edge k+2 and on pix_color after edge k+4. The bench drives the counters at falling edges and records, for each step, the expected address, glyph address and colour in a ring. At every later falling edge it compares cell_addr, gly_addr and pix_color with the entries recorded one, three and five falling edges before. Address checks are skipped for positions outside the active area, where only the black output is defined. After a reset the step count restarts, so nothing is compared against pixels that the reset discarded.

// File: rtl/txt_pkg.sv
package txt_pkg;
  // Width of one colour index; an attribute byte holds two of them.
  localparam int COLOR_W = 4;
  localparam int ATTR_W  = 2 * COLOR_W;

  typedef logic [COLOR_W-1:0] color_t;

  // Attribute layout: background in the upper half, foreground in the lower.
  typedef struct packed {
    color_t bg;
    color_t fg;
  } attr_t;
endpackage

// File: rtl/txt_pipe_dly.sv
// Resettable delay line of N register stages, W bits wide.
module txt_pipe_dly #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_stg
    logic [W-1:0] r;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_stg[i-1].r;
      end
    end
  end

  assign q = g_stg[N-1].r;
endmodule

// File: rtl/txt_addr_gen.sv
// Stage 0: decode raster counters into a cell index and per-pixel side data.
module txt_addr_gen #(
  parameter int COLS_N  = 40,
  parameter int COLS_W  = 80,
  parameter int ROWS    = 25,
  parameter int CELL_W  = 8,
  parameter int CELL_H  = 8,
  parameter int X_W     = 10,
  parameter int Y_W     = 10,
  parameter int BIT_W   = 3,
  parameter int LINE_SH = 3,
  parameter int BUF_AW  = 11,
  parameter int COL_W   = 7,
  parameter int ROW_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wide,
  input  logic [X_W-1:0]     pix_x,
  input  logic [Y_W-1:0]     pix_y,
  input  logic [COL_W-1:0]   cur_col,
  input  logic [ROW_W-1:0]   cur_row,
  input  logic               cur_blink,
  output logic [BUF_AW-1:0]  cell_addr,
  output logic [LINE_SH-1:0] line_q,
  output logic [BIT_W-1:0]   bit_q,
  output logic               act_q,
  output logic               hit_q
);
  localparam logic [X_W-1:0] XLIM_N = X_W'(COLS_N * CELL_W);
  localparam logic [X_W-1:0] XLIM_W = X_W'(COLS_W * CELL_W);
  localparam logic [Y_W-1:0] YLIM   = Y_W'(ROWS * CELL_H);

  logic [Y_W-1:0]    y_eff;
  logic [X_W-1:0]    col_idx;
  logic [X_W-1:0]    x_lim;
  logic [Y_W-1:0]    row_idx;
  logic [BUF_AW-1:0] cols;
  logic [BUF_AW-1:0] idx;
  logic              in_area;
  logic              on_cursor;

  always_comb begin
    // Line doubling: the wide geometry halves the line counter.
    y_eff     = wide ? (pix_y >> 1) : pix_y;
    col_idx   = pix_x >> BIT_W;
    row_idx   = y_eff >> LINE_SH;
    cols      = wide ? BUF_AW'(COLS_W) : BUF_AW'(COLS_N);
    x_lim     = wide ? XLIM_W : XLIM_N;
    in_area   = (pix_x < x_lim) && (y_eff < YLIM);
    idx       = BUF_AW'(row_idx) * cols + BUF_AW'(col_idx);
    on_cursor = cur_blink && (col_idx == X_W'(cur_col)) && (row_idx == Y_W'(cur_row));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_addr <= '0;
      line_q    <= '0;
      bit_q     <= '0;
      act_q     <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      cell_addr <= idx;
      line_q    <= y_eff[LINE_SH-1:0];
      bit_q     <= pix_x[BIT_W-1:0];
      act_q     <= in_area;
      hit_q     <= on_cursor && in_area;
    end
  end
endmodule

// File: rtl/txt_glyph_stage.sv
// Stage 2: form the glyph address from the returned code and capture the attribute.
module txt_glyph_stage #(
  parameter int CODE_W  = 8,
  parameter int LINE_SH = 3,
  parameter int ATTR_W  = 8,
  parameter int GLY_AW  = CODE_W + LINE_SH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  code,
  input  logic [LINE_SH-1:0] line,
  input  logic [ATTR_W-1:0]  attr_in,
  output logic [GLY_AW-1:0]  gly_addr,
  output logic [ATTR_W-1:0]  attr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gly_addr <= '0;
      attr_q   <= '0;
    end else begin
      // Cell height is a power of two: code*CELL_H + line is a concatenation.
      gly_addr <= {code, line};
      attr_q   <= attr_in;
    end
  end
endmodule

// File: rtl/txt_pix_out.sv
// Stage 4: pick the glyph bit and drive the registered colour index.
module txt_pix_out
  import txt_pkg::*;
#(
  parameter int CELL_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CELL_W-1:0] gly_row,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [ATTR_W-1:0] attr_raw,
  input  logic              act,
  input  logic              hit,
  output color_t            pix
);
  attr_t            attr;
  logic [BIT_W-1:0] sel;
  logic             lit;

  always_comb begin
    attr = attr_t'(attr_raw);
    sel  = BIT_W'(CELL_W - 1) - bit_idx;
    lit  = gly_row[sel];
  end

  always_ff @(posedge clk) begin
    if (rst)             pix <= '0;
    else if (!act)       pix <= '0;
    else if (lit ^ hit)  pix <= attr.fg;
    else                 pix <= attr.bg;
  end
endmodule

// File: rtl/txt_cell_render.sv
module txt_cell_render
  import txt_pkg::*;
#(
  parameter int COLS_N = 40,
  parameter int COLS_W = 80,
  parameter int ROWS   = 25,
  parameter int CELL_W = 8,
  parameter int CELL_H = 8,
  parameter int CODE_W = 8,
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  localparam int BIT_W   = $clog2(CELL_W),
  localparam int LINE_SH = $clog2(CELL_H),
  localparam int BUF_AW  = $clog2(COLS_W * ROWS),
  localparam int GLY_AW  = CODE_W + LINE_SH,
  localparam int COL_W   = $clog2(COLS_W),
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  input  logic [COL_W-1:0]  cur_col,
  input  logic [ROW_W-1:0]  cur_row,
  input  logic              cur_blink,
  output logic [BUF_AW-1:0] cell_addr,
  input  logic [CODE_W-1:0] chr_data,
  input  logic [ATTR_W-1:0] att_data,
  output logic [GLY_AW-1:0] gly_addr,
  input  logic [CELL_W-1:0] gly_data,
  output logic [COLOR_W-1:0] pix_color
);
  localparam int SIDE_W = BIT_W + 2;

  // Stage outputs; suffix gives the cycle in which the value is valid.
  logic [LINE_SH-1:0] line_s1, line_s2;
  logic [BIT_W-1:0]   bit_s1,  bit_s4;
  logic               act_s1,  act_s4;
  logic               hit_s1,  hit_s4;
  logic [ATTR_W-1:0]  attr_s3, attr_s4;

  txt_addr_gen #(
    .COLS_N(COLS_N), .COLS_W(COLS_W), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
    .X_W(X_W), .Y_W(Y_W), .BIT_W(BIT_W), .LINE_SH(LINE_SH), .BUF_AW(BUF_AW),
    .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_addr (
    .clk(clk), .rst(rst), .wide(wide_mode), .pix_x(pix_x), .pix_y(pix_y),
    .cur_col(cur_col), .cur_row(cur_row), .cur_blink(cur_blink),
    .cell_addr(cell_addr), .line_q(line_s1), .bit_q(bit_s1),
    .act_q(act_s1), .hit_q(hit_s1)
  );

  // Bitmap row waits one cycle for the code read.
  txt_pipe_dly #(.W(LINE_SH), .N(1)) u_line_dly (
    .clk(clk), .rst(rst), .d(line_s1), .q(line_s2)
  );

  // Pixel position and flags wait for both reads.
  txt_pipe_dly #(.W(SIDE_W), .N(3)) u_side_dly (
    .clk(clk), .rst(rst),
    .d({bit_s1, act_s1, hit_s1}),
    .q({bit_s4, act_s4, hit_s4})
  );

  txt_glyph_stage #(
    .CODE_W(CODE_W), .LINE_SH(LINE_SH), .ATTR_W(ATTR_W), .GLY_AW(GLY_AW)
  ) u_glyph (
    .clk(clk), .rst(rst), .code(chr_data), .line(line_s2),
    .attr_in(att_data), .gly_addr(gly_addr), .attr_q(attr_s3)
  );

  // Attribute waits for the glyph read.
  txt_pipe_dly #(.W(ATTR_W), .N(1)) u_attr_dly (
    .clk(clk), .rst(rst), .d(attr_s3), .q(attr_s4)
  );

  txt_pix_out #(.CELL_W(CELL_W), .BIT_W(BIT_W)) u_pix (
    .clk(clk), .rst(rst), .gly_row(gly_data), .bit_idx(bit_s4),
    .attr_raw(attr_s4), .act(act_s4), .hit(hit_s4), .pix(pix_color)
  );
endmodule

// File: rtl/txt_cell_render_chk.sv
module txt_cell_render_chk #(
  parameter int COLS_N = 40,
  parameter int COLS_W = 80,
  parameter int ROWS   = 25,
  parameter int CELL_W = 8,
  parameter int CELL_H = 8,
  parameter int CODE_W = 8,
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  localparam int LINE_SH = $clog2(CELL_H),
  localparam int BUF_AW  = $clog2(COLS_W * ROWS),
  localparam int GLY_AW  = CODE_W + LINE_SH,
  localparam int CW      = txt_pkg::COLOR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_mode,
  input logic [X_W-1:0]    pix_x,
  input logic [Y_W-1:0]    pix_y,
  input logic [BUF_AW-1:0] cell_addr,
  input logic [CODE_W-1:0] chr_data,
  input logic [2*CW-1:0]   att_data,
  input logic [GLY_AW-1:0] gly_addr,
  input logic [CW-1:0]     pix_color
);
  int                 xi, yi, cols;
  logic               in_act;
  logic [BUF_AW-1:0]  in_idx;
  logic [LINE_SH-1:0] in_line;
  logic [2:0]         since_rst;

  always_comb begin
    xi      = int'(pix_x);
    yi      = wide_mode ? int'(pix_y) / 2 : int'(pix_y);
    cols    = wide_mode ? COLS_W : COLS_N;
    in_act  = (xi < cols * CELL_W) && (yi < ROWS * CELL_H);
    in_idx  = BUF_AW'((yi / CELL_H) * cols + xi / CELL_W);
    in_line = LINE_SH'(yi % CELL_H);
  end

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R1 and R2: cell index loaded on the sampling edge.
  p_cell_index_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $past(in_act)) |-> cell_addr == $past(in_idx));

  p_glyph_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3 && $past(in_act, 3)) |->
      (gly_addr[LINE_SH-1:0] == $past(in_line, 3)) &&
      (gly_addr[GLY_AW-1:LINE_SH] == $past(chr_data, 1)));

  // R4 and R5: an active pixel is one of the two colours of its cell, four edges on.
  p_pix_from_attr_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && $past(in_act, 5)) |->
      (pix_color == $past(att_data[CW-1:0], 3)) ||
      (pix_color == $past(att_data[2*CW-1:CW], 3)));

  p_blank_outside_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && !$past(in_act, 5)) |-> pix_color == '0);
endmodule

bind txt_cell_render txt_cell_render_chk #(
  .COLS_N(COLS_N), .COLS_W(COLS_W), .ROWS(ROWS), .CELL_W(CELL_W),
  .CELL_H(CELL_H), .CODE_W(CODE_W), .X_W(X_W), .Y_W(Y_W)
) u_chk (
  .clk(clk), .rst(rst), .wide_mode(wide_mode), .pix_x(pix_x), .pix_y(pix_y),
  .cell_addr(cell_addr), .chr_data(chr_data), .att_data(att_data),
  .gly_addr(gly_addr), .pix_color(pix_color)
);

// File: tb/txt_cell_render_bench.sv
module txt_cell_render_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide = 1'b0;
  logic        blink = 1'b0;
  logic [9:0]  px = '0;
  logic [9:0]  py = '0;
  logic [6:0]  ccol = '0;
  logic [4:0]  crow = '0;
  logic [10:0] cell_addr, gly_addr;
  logic [7:0]  chr_q, att_q, gly_q;
  logic [3:0]  pix;

  logic [7:0] chr_mem [2048];
  logic [7:0] att_mem [2048];
  logic [7:0] gly_mem [2048];

  int checks = 0;
  int fails  = 0;
  int s      = 0;
  bit done   = 1'b0;

  // Expected-value ring, indexed by step modulo 8.
  bit    h_act [8];
  bit    h_w   [8];
  int    h_idx [8];
  int    h_gad [8];
  int    h_col [8];
  string h_req [8];

  always #4 clk = ~clk;

  // Synchronous memories with one cycle of read latency.
  always @(posedge clk) begin
    chr_q <= chr_mem[cell_addr];
    att_q <= att_mem[cell_addr];
    gly_q <= gly_mem[gly_addr];
  end

  txt_cell_render u_txt_cell_render (
    .clk(clk), .rst(rst), .wide_mode(wide), .pix_x(px), .pix_y(py),
    .cur_col(ccol), .cur_row(crow), .cur_blink(blink),
    .cell_addr(cell_addr), .chr_data(chr_q), .att_data(att_q),
    .gly_addr(gly_addr), .gly_data(gly_q), .pix_color(pix)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d step=%0d", req, what, act, exp, s);
    end
  endtask

  function automatic void model(input int x, input int y, input bit w, input int cc,
                                input int cr, input bit bl, output bit act, output int idx,
                                output int gad, output int col, output string req);
    int cols, ye, c, r, a, fg, bg, g, t;
    bit on;
    cols = w ? 80 : 40;
    ye   = w ? y / 2 : y;
    c    = x / 8;
    r    = ye / 8;
    act  = (x < cols * 8) && (ye < 200);
    idx  = r * cols + c;
    gad  = 0;
    col  = 0;
    req  = "R6";
    if (act) begin
      gad = int'(chr_mem[idx]) * 8 + ye % 8;
      g   = int'(gly_mem[gad]);
      a   = int'(att_mem[idx]);
      fg  = a % 16;
      bg  = a / 16;
      on  = ((g >> (7 - x % 8)) & 1) == 1;
      req = w ? "R2/R5" : "R4/R5";
      if (bl && c == (cc % 128) && r == (cr % 32)) begin
        t = fg; fg = bg; bg = t;
        req = "R7";
      end
      col = on ? fg : bg;
    end
  endfunction

  // One pixel clock: check due outputs, then drive the next counter value.
  task automatic step(input int x, input int y, input bit w, input int cc, input int cr,
                      input bit bl);
    int k;
    @(negedge clk);
    if (s >= 1 && h_act[(s-1)%8])
      chk(h_w[(s-1)%8] ? "R2" : "R1", "cell_addr", int'(cell_addr), h_idx[(s-1)%8]);
    if (s >= 3 && h_act[(s-3)%8])
      chk("R3", "gly_addr", int'(gly_addr), h_gad[(s-3)%8]);
    if (s >= 5)
      chk(h_req[(s-5)%8], "pix_color", int'(pix), h_col[(s-5)%8]);
    px = 10'(x); py = 10'(y); wide = w;
    ccol = 7'(cc); crow = 5'(cr); blink = bl;
    k = s % 8;
    h_w[k] = w;
    model(x, y, w, cc, cr, bl, h_act[k], h_idx[k], h_gad[k], h_col[k], h_req[k]);
    s++;
  endtask

  task automatic flush();
    for (int i = 0; i < 6; i++) step(1000, 1000, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic reset_check();
    chk("R8", "pix_color", int'(pix), 0);
    chk("R8", "cell_addr", int'(cell_addr), 0);
    chk("R8", "gly_addr", int'(gly_addr), 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      chr_mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
      att_mem[i] = 8'(i * 53 + 7);
      gly_mem[i] = 8'((i * 97) ^ (i >> 2) ^ 8'h5a);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ys_n [8]  = '{0, 1, 7, 8, 99, 199, 200, 210};
    int ys_w [10] = '{0, 1, 2, 3, 15, 16, 17, 398, 399, 400};
    int unsigned r;
    int x, y, cc, cr;
    bit w, bl;

    // R8: reset state.
    repeat (3) @(negedge clk);
    reset_check();
    rst = 1'b0;
    s = 0;

    // R1, R4, R6: 40-column sweeps including right and bottom borders.
    foreach (ys_n[j]) for (int xx = 0; xx < 336; xx++) step(xx, ys_n[j], 1'b0, 99, 31, 1'b0);

    // R2, R6: 80-column sweeps with doubled lines and borders.
    foreach (ys_w[j]) for (int xx = 0; xx < 656; xx++) step(xx, ys_w[j], 1'b1, 99, 31, 1'b0);

    // R7: cursor overlay on, narrow geometry, interior and corner cells.
    for (int yy = 16; yy < 24; yy++) for (int xx = 0; xx < 72; xx++) step(xx, yy, 1'b0, 5, 2, 1'b1);
    for (int yy = 192; yy < 200; yy++) for (int xx = 300; xx < 328; xx++) step(xx, yy, 1'b0, 39, 24, 1'b1);
    // R7: blink off leaves the cursor cell untouched.
    for (int xx = 32; xx < 56; xx++) step(xx, 20, 1'b0, 5, 2, 1'b0);
    // R7: wide geometry, last cell.
    for (int yy = 384; yy < 402; yy++) for (int xx = 620; xx < 646; xx++) step(xx, yy, 1'b1, 79, 24, 1'b1);

    // R8: reset in mid-run with pixels in flight.
    for (int xx = 0; xx < 3; xx++) step(xx * 9, 40, 1'b0, 0, 0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    reset_check();
    rst = 1'b0;
    s = 0;

    // R1 to R7: scattered counters, mixed modes and cursor placements.
    r = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      x  = int'(r % 700);
      y  = int'((r >> 10) % 420);
      w  = r[20];
      bl = r[22];
      cc = r[21] ? x / 8 : int'(r % 80);
      cr = r[23] ? (w ? y / 16 : y / 8) : int'((r >> 4) % 25);
      step(x, y, w, cc, cr, bl);
    end

    flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule